// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

A 4-bit presettable counter that takes its count direction from which of two strobe lines produces a rising edge, rather than from a direction pin. A rising edge on the up strobe, seen while the down strobe rests high, adds one. A rising edge on the down strobe, seen while the up strobe rests high, subtracts one. Both strobes run through a two-flop synchronizer into the single system clock domain, and the edges are detected on the synchronized levels. A build parameter selects the modulus: decade (0 to 9) or full binary (0 to 15).

A synchronous active-high clear and an active-low parallel load set the count directly. Clear outranks load, and load outranks counting. Two active-low outputs support cascading. The carry output is low while the count sits at its terminal value and the up strobe is low. The borrow output is low while the count is zero and the down strobe is low. Because each of these pulses ends with a rising edge at the same moment the count wraps, carry can drive the up strobe of a following stage and borrow its down strobe.

Top module: `dual_strobe_counter`

## Requirements
- R1: A rising edge on the up strobe while the down strobe is high increments the count, and a rising edge on the down strobe while the up strobe is high decrements it. A strobe raised between clock edges shows on the count output after the third following rising clock edge and not after the second. An edge on one strobe while the other is low changes nothing.
- R2: When the clear input is high at a clock edge, the count becomes 0 at that edge, whatever the load, data and strobe inputs do.
- R3: When clear is low and the load input is low at a clock edge, the count takes the 4-bit data word at that edge, with or without a strobe edge.
- R4: In decade mode, counting up wraps from 9 to 0 and counting down wraps from 0 to 9. From 7, up edges give 8, 9, 0, 1, 2, and down edges from 2 give 1, 0, 9, 8, 7.
- R5: In binary mode, counting up wraps from 15 to 0 and counting down wraps from 0 to 15. From 13, up edges give 14, 15, 0, 1, 2, and down edges from 2 give 1, 0, 15, 14, 13.
- R6: Carry is low exactly while the count equals the terminal value (9 in decade mode, 15 in binary mode) and the synchronized up strobe is low. At all other times it is high.
- R7: Borrow is low exactly while the count equals 0 and the synchronized down strobe is low. At all other times it is high.
- R8: Rising edges on both strobes in the same cycle are ignored, and the count keeps its value.
- R9: In decade mode, a loaded value from 10 to 15 steps as plain binary: up gives +1 with 15 going to 0, and down gives -1. None of these values produces a carry or a borrow.
- R10: After reset, the count is 0 and carry and borrow are both high.
- R11: When carry feeds a second stage's up strobe and borrow feeds its down strobe, the second stage advances by one when the first stage wraps upward and falls by one when the first stage wraps downward.
- R12: Without clear, load or a qualified strobe edge, the count holds its value, and changes on the data input have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear, active high, highest priority |
| load_ni | input | 1 | Synchronous parallel load, active low |
| data_i | input | CNT_W | Preset value copied on load |
| up_i | input | 1 | Up-count strobe, idle high, counts on its rising edge |
| dn_i | input | 1 | Down-count strobe, idle high, counts on its rising edge |
| cnt_o | output | CNT_W | Current count |
| carry_no | output | 1 | Active-low overflow pulse for cascading |
| borrow_no | output | 1 | Active-low underflow pulse for cascading |

## Verification
The bench builds three instances from shared stimulus. One uses DECADE=1 and one uses DECADE=0, so each strobe sequence exercises both wrap points and the out-of-range decade values 10 to 15 side by side with their binary counterparts. A third decade instance takes the first decade instance's carry and borrow as its strobes, which brings the two-stage advance and retreat within reach. The cases covered include the exact latency of the synchronizer, edges made while the other strobe is low, and simultaneous edges on both strobes.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    // One bit per strobe direction
    typedef struct packed {
        logic up;
        logic dn;
    } dsc_pair_t;

    // Action chosen for the count register in a cycle, highest priority first
    typedef enum logic [2:0] {
        DSC_CLEAR,
        DSC_LOAD,
        DSC_UP,
        DSC_DOWN,
        DSC_HOLD
    } dsc_act_e;

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    // Shift chain: stage 0 samples the raw line, later stages follow
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_d[g] = d_i;
        end else begin : g_rest
            assign chain_d[g] = chain_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{IDLE}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dsc_strobe_edge.sv
module dsc_strobe_edge
    import dsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dsc_pair_t lvl_i,
    output dsc_pair_t rise_o,
    output dsc_pair_t step_o
);

    typedef struct packed {
        dsc_pair_t prev;
    } edge_state_t;

    edge_state_t state_d;
    edge_state_t state_q;

    always_comb begin
        state_d      = state_q;
        state_d.prev = lvl_i;

        rise_o.up = lvl_i.up & ~state_q.prev.up;
        rise_o.dn = lvl_i.dn & ~state_q.prev.dn;

        // A strobe edge counts only while the other line rests high,
        // and two edges in one cycle cancel.
        step_o.up = rise_o.up & lvl_i.dn & ~rise_o.dn;
        step_o.dn = rise_o.dn & lvl_i.up & ~rise_o.up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{prev: '{up: 1'b1, dn: 1'b1}};
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/dsc_count_core.sv
module dsc_count_core
    import dsc_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter bit DECADE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_ni,
    input  logic [CNT_W-1:0] data_i,
    input  dsc_pair_t        step_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] TOP_VAL = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_state_t;

    core_state_t state_d;
    core_state_t state_q;
    dsc_act_e    act;

    // Up step: terminal wraps to zero; out-of-range values wrap naturally
    function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] v);
        return (v == TOP_VAL) ? '0 : v + CNT_W'(1);
    endfunction

    // Down step: zero wraps to terminal; everything else subtracts one
    function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
        return (v == '0) ? TOP_VAL : v - CNT_W'(1);
    endfunction

    always_comb begin
        if (clr_i) begin
            act = DSC_CLEAR;
        end else if (!load_ni) begin
            act = DSC_LOAD;
        end else if (step_i.up) begin
            act = DSC_UP;
        end else if (step_i.dn) begin
            act = DSC_DOWN;
        end else begin
            act = DSC_HOLD;
        end

        state_d = state_q;
        unique case (act)
            DSC_CLEAR: state_d.cnt = '0;
            DSC_LOAD:  state_d.cnt = data_i;
            DSC_UP:    state_d.cnt = step_up(state_q.cnt);
            DSC_DOWN:  state_d.cnt = step_down(state_q.cnt);
            default:   state_d.cnt = state_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{cnt: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o = state_q.cnt;

endmodule

// File: rtl/dsc_cascade_out.sv
module dsc_cascade_out #(
    parameter int CNT_W  = 4,
    parameter bit DECADE = 1'b1
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             up_lvl_i,
    input  logic             dn_lvl_i,
    output logic             carry_no,
    output logic             borrow_no
);

    localparam logic [CNT_W-1:0] TOP_VAL = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

    logic at_top;
    logic at_zero;

    always_comb begin
        at_top    = (cnt_i == TOP_VAL);
        at_zero   = (cnt_i == '0);
        // Pulses follow the strobe's low phase so they end with a rising edge
        carry_no  = ~(at_top  & ~up_lvl_i);
        borrow_no = ~(at_zero & ~dn_lvl_i);
    end

endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
    import dsc_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter bit DECADE      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_ni,
    input  logic [CNT_W-1:0] data_i,
    input  logic             up_i,
    input  logic             dn_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             carry_no,
    output logic             borrow_no
);

    dsc_pair_t raw_w;
    dsc_pair_t lvl_w;
    dsc_pair_t rise_w;
    dsc_pair_t step_w;

    assign raw_w.up = up_i;
    assign raw_w.dn = dn_i;

    dsc_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) i_sync_up (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_w.up),
        .q_o   (lvl_w.up)
    );

    dsc_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) i_sync_dn (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_w.dn),
        .q_o   (lvl_w.dn)
    );

    dsc_strobe_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_w),
        .rise_o (rise_w),
        .step_o (step_w)
    );

    dsc_count_core #(.CNT_W(CNT_W), .DECADE(DECADE)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .load_ni (load_ni),
        .data_i  (data_i),
        .step_i  (step_w),
        .cnt_o   (cnt_o)
    );

    dsc_cascade_out #(.CNT_W(CNT_W), .DECADE(DECADE)) i_out (
        .cnt_i     (cnt_o),
        .up_lvl_i  (lvl_w.up),
        .dn_lvl_i  (lvl_w.dn),
        .carry_no  (carry_no),
        .borrow_no (borrow_no)
    );

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
    import dsc_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter bit DECADE = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             load_ni,
    input logic [CNT_W-1:0] data_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic             carry_no,
    input logic             borrow_no,
    input dsc_pair_t        rise_i,
    input dsc_pair_t        step_i
);

    localparam logic [CNT_W-1:0] TOP_VAL = DECADE ? CNT_W'(9) : {CNT_W{1'b1}};

    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

    a_r3_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !load_ni) |=> (cnt_o == $past(data_i)));

    a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && load_ni && step_i.up && cnt_o != TOP_VAL)
        |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && load_ni && !step_i.up && !step_i.dn) |=> $stable(cnt_o));

    a_r8_both_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && load_ni && rise_i.up && rise_i.dn) |=> $stable(cnt_o));

    a_r6_carry_term: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_no |-> (cnt_o == TOP_VAL));

    a_r7_borrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_no |-> (cnt_o == '0));

    a_r4_decade_range: assert property (@(posedge clk) disable iff (!rst_n)
        (DECADE && cnt_o <= CNT_W'(9) && load_ni) |=> (cnt_o <= CNT_W'(9)));

endmodule

bind dual_strobe_counter dsc_checker #(.CNT_W(CNT_W), .DECADE(DECADE)) i_dsc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .load_ni   (load_ni),
    .data_i    (data_i),
    .cnt_o     (cnt_o),
    .carry_no  (carry_no),
    .borrow_no (borrow_no),
    .rise_i    (rise_w),
    .step_i    (step_w)
);

// File: tb/test_dual_strobe_counter.sv
module test_dual_strobe_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] data = 4'd0;
    logic       up = 1'b1;
    logic       dn = 1'b1;

    logic [3:0] dec_cnt, bin_cnt, hi_cnt;
    logic       dec_carry_n, dec_borrow_n;
    logic       bin_carry_n, bin_borrow_n;
    logic       hi_carry_n, hi_borrow_n;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dual_strobe_counter #(.CNT_W(4), .DECADE(1'b1)) i_dual_strobe_counter (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .load_ni(load_n), .data_i(data),
        .up_i(up), .dn_i(dn), .cnt_o(dec_cnt), .carry_no(dec_carry_n), .borrow_no(dec_borrow_n)
    );

    dual_strobe_counter #(.CNT_W(4), .DECADE(1'b0)) i_bin (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .load_ni(load_n), .data_i(data),
        .up_i(up), .dn_i(dn), .cnt_o(bin_cnt), .carry_no(bin_carry_n), .borrow_no(bin_borrow_n)
    );

    dual_strobe_counter #(.CNT_W(4), .DECADE(1'b1)) i_hi (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .load_ni(load_n), .data_i(data),
        .up_i(dec_carry_n), .dn_i(dec_borrow_n), .cnt_o(hi_cnt), .carry_no(hi_carry_n),
        .borrow_no(hi_borrow_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(input logic [3:0] v);
        data = v;
        load_n = 1'b0;
        tick(1);
        load_n = 1'b1;
        tick(1);
    endtask

    task automatic up_pulse();
        up = 1'b0;
        tick(4);
        up = 1'b1;
        tick(5);
    endtask

    task automatic dn_pulse();
        dn = 1'b0;
        tick(4);
        dn = 1'b1;
        tick(5);
    endtask

    task automatic t_reset();
        chk("R10 count after reset", dec_cnt, 0);
        chk("R10 carry after reset", dec_carry_n, 1);
        chk("R10 borrow after reset", dec_borrow_n, 1);
        chk("R10 binary count after reset", bin_cnt, 0);
    endtask

    task automatic t_load_and_clear();
        do_load(4'd7);
        chk("R3 decade load 7", dec_cnt, 7);
        chk("R3 binary load 7", bin_cnt, 7);
        // load together with a strobe edge still loads
        up = 1'b0;
        tick(4);
        up = 1'b1;
        data = 4'd5;
        load_n = 1'b0;
        tick(6);
        load_n = 1'b1;
        tick(1);
        chk("R3 load over strobe edge", dec_cnt, 5);
        // clear beats load, data and strobe
        clr = 1'b1;
        load_n = 1'b0;
        data = 4'd9;
        up = 1'b0;
        tick(3);
        up = 1'b1;
        tick(5);
        chk("R2 clear over load and strobe", dec_cnt, 0);
        chk("R2 clear binary", bin_cnt, 0);
        clr = 1'b0;
        load_n = 1'b1;
        tick(1);
        chk("R2 count stays 0 after clear", dec_cnt, 0);
    endtask

    task automatic t_latency();
        do_load(4'd3);
        up = 1'b0;
        tick(4);
        up = 1'b1;
        tick(2);
        chk("R1 no change after second edge", dec_cnt, 3);
        tick(1);
        chk("R1 increment after third edge", dec_cnt, 4);
        tick(3);
        dn_pulse();
        chk("R1 decrement", dec_cnt, 3);
    endtask

    task automatic t_decade_binary_seq();
        int dec_up[5] = '{8, 9, 0, 1, 2};
        int bin_up[5] = '{8, 9, 10, 11, 12};
        int dec_dn[5] = '{1, 0, 9, 8, 7};
        int bin_dn[5] = '{11, 10, 9, 8, 7};
        do_load(4'd7);
        for (int i = 0; i < 5; i++) begin
            up_pulse();
            chk("R4 decade up sequence", dec_cnt, dec_up[i]);
            chk("R1 binary up from 7", bin_cnt, bin_up[i]);
        end
        for (int i = 0; i < 5; i++) begin
            dn_pulse();
            chk("R4 decade down sequence", dec_cnt, dec_dn[i]);
            chk("R1 binary down from 12", bin_cnt, bin_dn[i]);
        end
    endtask

    task automatic t_binary_wrap();
        int up_seq[5] = '{14, 15, 0, 1, 2};
        int bin_dn[5] = '{1, 0, 15, 14, 13};
        int dec_dn[5] = '{1, 0, 9, 8, 7};
        do_load(4'd13);
        for (int i = 0; i < 5; i++) begin
            up_pulse();
            chk("R5 binary up sequence", bin_cnt, up_seq[i]);
            chk("R9 decade out-of-range up", dec_cnt, up_seq[i]);
        end
        for (int i = 0; i < 5; i++) begin
            dn_pulse();
            chk("R5 binary down sequence", bin_cnt, bin_dn[i]);
            chk("R4 decade down after wrap", dec_cnt, dec_dn[i]);
        end
    endtask

    task automatic t_carry_borrow();
        do_load(4'd9);
        chk("R6 carry high while up strobe idle", dec_carry_n, 1);
        up = 1'b0;
        tick(4);
        chk("R6 decade carry low at 9", dec_carry_n, 0);
        chk("R6 binary carry high at 9", bin_carry_n, 1);
        up = 1'b1;
        tick(5);
        chk("R6 carry released after wrap", dec_carry_n, 1);
        chk("R4 decade 9 to 0", dec_cnt, 0);
        dn = 1'b0;
        tick(4);
        chk("R7 decade borrow low at 0", dec_borrow_n, 0);
        chk("R7 binary borrow high at 10", bin_borrow_n, 1);
        dn = 1'b1;
        tick(5);
        chk("R7 borrow released", dec_borrow_n, 1);
        chk("R4 decade 0 to 9", dec_cnt, 9);
        do_load(4'd15);
        up = 1'b0;
        tick(4);
        chk("R6 binary carry low at 15", bin_carry_n, 0);
        chk("R9 decade no carry at 15", dec_carry_n, 1);
        up = 1'b1;
        tick(5);
        chk("R9 decade 15 to 0", dec_cnt, 0);
        chk("R5 binary 15 to 0", bin_cnt, 0);
        do_load(4'd10);
        dn = 1'b0;
        tick(4);
        chk("R9 decade no borrow at 10", dec_borrow_n, 1);
        dn = 1'b1;
        tick(5);
        chk("R9 decade 10 down to 9", dec_cnt, 9);
        do_load(4'd0);
        dn = 1'b0;
        tick(4);
        chk("R7 binary borrow low at 0", bin_borrow_n, 0);
        dn = 1'b1;
        tick(5);
        chk("R5 binary 0 to 15", bin_cnt, 15);
    endtask

    task automatic t_other_low();
        do_load(4'd4);
        up = 1'b0;
        tick(4);
        dn = 1'b0;
        tick(4);
        dn = 1'b1;
        tick(5);
        chk("R1 down edge ignored while up low", dec_cnt, 4);
        up = 1'b1;
        tick(5);
        chk("R1 up edge with down high counts", dec_cnt, 5);
    endtask

    task automatic t_both();
        do_load(4'd4);
        up = 1'b0;
        dn = 1'b0;
        tick(4);
        up = 1'b1;
        dn = 1'b1;
        tick(5);
        chk("R8 simultaneous edges ignored decade", dec_cnt, 4);
        chk("R8 simultaneous edges ignored binary", bin_cnt, 4);
    endtask

    task automatic t_hold();
        do_load(4'd6);
        data = 4'd11;
        tick(20);
        chk("R12 hold with data change", dec_cnt, 6);
        chk("R12 hold binary", bin_cnt, 6);
    endtask

    task automatic t_cascade();
        do_load(4'd8);
        chk("R11 upper stage loaded", hi_cnt, 8);
        up_pulse();
        chk("R11 lower stage 9", dec_cnt, 9);
        chk("R11 upper stage unchanged", hi_cnt, 8);
        up = 1'b0;
        tick(4);
        up = 1'b1;
        tick(10);
        chk("R11 lower stage wraps to 0", dec_cnt, 0);
        chk("R11 upper stage advances", hi_cnt, 9);
        dn = 1'b0;
        tick(4);
        dn = 1'b1;
        tick(10);
        chk("R11 lower stage wraps to 9", dec_cnt, 9);
        chk("R11 upper stage falls back", hi_cnt, 8);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_load_and_clear();
        t_latency();
        t_decade_binary_seq();
        t_binary_wrap();
        t_carry_borrow();
        t_other_low();
        t_both();
        t_hold();
        t_cascade();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule